// File: doc/BRIEF.md
# Dual-Mode External Bus Arbitration Unit

This block decides who owns a shared external bus: the on-chip master or one of the external masters. The request, grant and busy lines are all active low. A static mode input selects the role. In arbiter mode the block accepts external requests and hands out grants. It holds busy low for the on-chip master's tenures, and it sees the end of an external tenure when the external busy line returns high. In requester mode the block asks an outside arbiter for the bus. It takes the bus only on a qualified grant, which means grant low while busy is high.

The on-chip master uses a level request, a one-cycle done pulse and a one-cycle start pulse. The block answers with an ownership flag. As bus owner it drives a transfer-start strobe, and while an external master holds the bus it raises burst-inhibit for that master's bursts into on-chip memory. The pins change direction with the mode, so each one is modelled as a separate input and output. Every output comes from a flop, so each response appears one clock after the sampled input.

Top module: `ebarb_top`

## Requirements
- R1: While rst is high and on the first edge after it, the outputs req_out_n, grant_out_n, busy_out_n, sts_out_n and bi_out_n are 1 and int_own is 0.
- R2: In arbiter mode (arb_mode=1) with the bus parked, an int_req with no external request drives busy_out_n to 0 and int_own to 1 on the next edge. An int_done pulse drives both back on the next edge.
- R3: In arbiter mode, with the bus parked and only req_in_n low, grant_out_n goes to 0 on the next edge. While grant_out_n is 0, busy_out_n stays 1.
- R4: The grant is withdrawn (grant_out_n=1) on the edge after busy_in_n is sampled low. After the external tenure ends (busy_in_n sampled high), grant_out_n stays 1 for at least one more edge before a new grant.
- R5: In arbiter mode, when int_req and req_in_n arrive together on a parked bus, the on-chip master is served first. At its int_done the pending external request is granted on the next edge, even if int_req is still high. After that external tenure, the on-chip master gets the bus again.
- R6: In requester mode (arb_mode=0), an int_req without a qualified grant drives req_out_n to 0 and leaves busy_out_n at 1.
- R7: In requester mode, busy_out_n goes to 0 only on the edge after a qualified grant (grant_in_n=0 and busy_in_n=1) is sampled. On that same edge req_out_n returns to 1 and int_own goes to 1. A grant sampled while busy_in_n=0 has no effect.
- R8: In requester mode, when a qualified grant is already present at the moment int_req rises (the bus is parked here), busy_out_n goes to 0 on the next edge and req_out_n never goes low.
- R9: An int_start pulse while int_own=1 (and no int_done) drives sts_out_n to 0 for exactly one cycle, starting on the next edge. An int_start while int_own=0 leaves sts_out_n at 1.
- R10: In arbiter mode, during an external tenure (busy_in_n=0 after a grant), an ext_sts_n low with ext_burst=1 and ext_hit_int=1 drives bi_out_n to 0 on the next edge. It holds until the next external start or until busy_in_n returns high. A start with ext_burst=0 or ext_hit_int=0 gives bi_out_n=1.
- R11: In arbiter mode req_out_n stays 1. In requester mode grant_out_n stays 1, even when req_in_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arb_mode | input | 1 | Static: 1 = arbiter mode, 0 = requester mode |
| int_req | input | 1 | On-chip master wants the bus (level) |
| int_done | input | 1 | On-chip tenure ends (one-cycle pulse) |
| int_start | input | 1 | On-chip transaction begins (one-cycle pulse) |
| int_own | output | 1 | On-chip master owns the bus |
| req_in_n | input | 1 | External request, arbiter mode, active low |
| req_out_n | output | 1 | Request to outside arbiter, requester mode, active low |
| grant_in_n | input | 1 | Grant from outside arbiter, active low |
| grant_out_n | output | 1 | Grant to external master, active low |
| busy_in_n | input | 1 | Busy driven by other masters, active low |
| busy_out_n | output | 1 | Busy driven for the on-chip master, active low |
| ext_sts_n | input | 1 | Transfer start by external master, active low |
| ext_burst | input | 1 | External transaction is a burst |
| ext_hit_int | input | 1 | External transaction targets on-chip memory |
| sts_out_n | output | 1 | Transfer-start strobe of the on-chip master, active low |
| bi_out_n | output | 1 | Burst inhibit, active low |

## Verification
The hardest state to reach is the hand-over in R5. The on-chip tenure has to be active while an external request is already pending. The done pulse has to arrive while int_req is still high, and only then can the bench see that the external master wins before the on-chip master is served again. The bench raises both requests in the same cycle on a parked bus. It keeps int_req high through the done pulse, and then acts as the external master by pulling busy_in_n low and releasing it. Burst-inhibit also needs an external tenure in progress, so that scenario follows its own grant and busy handshake and issues starts with different burst and address flags.

// File: rtl/ebarb_pkg.sv
package ebarb_pkg;

    // Arbiter-mode states
    typedef enum logic [1:0] {
        H_PARK  = 2'd0,
        H_OWN   = 2'd1,
        H_GRANT = 2'd2,
        H_EXT   = 2'd3
    } host_st_e;

    // Requester-mode states
    typedef enum logic [1:0] {
        Q_IDLE = 2'd0,
        Q_REQ  = 2'd1,
        Q_OWN  = 2'd2
    } req_st_e;

    // Active-high control bundle before pin inversion
    typedef struct packed {
        logic req;
        logic grant;
        logic busy;
        logic own;
    } bus_ctl_t;

    localparam bus_ctl_t CTL_NONE = '0;

    function automatic logic qual_grant(input logic gnt_n, input logic bsy_n);
        return !gnt_n && bsy_n;
    endfunction

endpackage

// File: rtl/ebarb_host_fsm.sv
module ebarb_host_fsm
    import ebarb_pkg::*;
(
    input  logic     clk,
    input  logic     clr,
    input  logic     ext_req,
    input  logic     ext_busy,
    input  logic     int_req,
    input  logic     int_done,
    output bus_ctl_t ctl_nxt,
    output logic     ext_tenure
);

    host_st_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        case (state)
            H_PARK: begin
                if (int_req)      state_nxt = H_OWN;
                else if (ext_req) state_nxt = H_GRANT;
            end
            H_OWN: begin
                if (int_done) state_nxt = ext_req ? H_GRANT : H_PARK;
            end
            H_GRANT: begin
                if (ext_busy)     state_nxt = H_EXT;
                else if (!ext_req) state_nxt = H_PARK;
            end
            H_EXT: begin
                if (!ext_busy) state_nxt = H_PARK;
            end
            default: state_nxt = H_PARK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) state <= H_PARK;
        else     state <= state_nxt;
    end

    always_comb begin
        ctl_nxt       = CTL_NONE;
        ctl_nxt.grant = (state_nxt == H_GRANT);
        ctl_nxt.busy  = (state_nxt == H_OWN);
        ctl_nxt.own   = (state_nxt == H_OWN);
    end

    assign ext_tenure = (state == H_GRANT) || (state == H_EXT);

    // R5: pending external request wins at the end of an on-chip tenure
    a_r5_no_starve: assert property (@(posedge clk) disable iff (clr)
        (state == H_OWN && int_done && ext_req) |=> (state == H_GRANT));

    // R4: a granted master that takes busy moves the arbiter to the tenure state
    a_r4_take_busy: assert property (@(posedge clk) disable iff (clr)
        (state == H_GRANT && ext_busy) |=> (state == H_EXT));

endmodule

// File: rtl/ebarb_req_fsm.sv
module ebarb_req_fsm
    import ebarb_pkg::*;
(
    input  logic     clk,
    input  logic     clr,
    input  logic     int_req,
    input  logic     int_done,
    input  logic     qgrant,
    output bus_ctl_t ctl_nxt
);

    req_st_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        case (state)
            Q_IDLE: if (int_req) state_nxt = qgrant ? Q_OWN : Q_REQ;
            Q_REQ:  if (qgrant)  state_nxt = Q_OWN;
            Q_OWN:  if (int_done) state_nxt = Q_IDLE;
            default: state_nxt = Q_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) state <= Q_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        ctl_nxt      = CTL_NONE;
        ctl_nxt.req  = (state_nxt == Q_REQ);
        ctl_nxt.busy = (state_nxt == Q_OWN);
        ctl_nxt.own  = (state_nxt == Q_OWN);
    end

    // R6: while requesting, ownership is taken only on a qualified grant
    a_r6_wait_grant: assert property (@(posedge clk) disable iff (clr)
        (state == Q_REQ && !qgrant) |=> (state == Q_REQ));

endmodule

// File: rtl/ebarb_strobe.sv
module ebarb_strobe (
    input  logic clk,
    input  logic rst,
    input  logic own_q,
    input  logic int_start,
    input  logic int_done,
    input  logic ext_tenure,
    input  logic ext_busy,
    input  logic ext_start,
    input  logic ext_burst,
    input  logic ext_hit_int,
    output logic sts_n,
    output logic bi_n
);

    logic ext_owner;
    assign ext_owner = ext_tenure && ext_busy;

    always_ff @(posedge clk) begin
        if (rst) sts_n <= 1'b1;
        else     sts_n <= !(int_start && own_q && !int_done);
    end

    always_ff @(posedge clk) begin
        if (rst || !ext_owner) bi_n <= 1'b1;
        else if (ext_start)    bi_n <= !(ext_burst && ext_hit_int);
    end

    // R9: the start strobe is a single-cycle pulse
    a_r9_sts_pulse: assert property (@(posedge clk) disable iff (rst)
        !sts_n |=> sts_n);

    // R10: inhibit only during an external tenure
    a_r10_bi_ext_only: assert property (@(posedge clk) disable iff (rst)
        !ext_owner |=> bi_n);

endmodule

// File: rtl/ebarb_top.sv
module ebarb_top
    import ebarb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arb_mode,
    input  logic int_req,
    input  logic int_done,
    input  logic int_start,
    output logic int_own,
    input  logic req_in_n,
    output logic req_out_n,
    input  logic grant_in_n,
    output logic grant_out_n,
    input  logic busy_in_n,
    output logic busy_out_n,
    input  logic ext_sts_n,
    input  logic ext_burst,
    input  logic ext_hit_int,
    output logic sts_out_n,
    output logic bi_out_n
);

    bus_ctl_t host_ctl, req_ctl, sel_ctl;
    logic     ext_tenure;

    ebarb_host_fsm u_host (
        .clk        (clk),
        .clr        (rst || !arb_mode),
        .ext_req    (!req_in_n),
        .ext_busy   (!busy_in_n),
        .int_req    (int_req),
        .int_done   (int_done),
        .ctl_nxt    (host_ctl),
        .ext_tenure (ext_tenure)
    );

    ebarb_req_fsm u_req (
        .clk      (clk),
        .clr      (rst || arb_mode),
        .int_req  (int_req),
        .int_done (int_done),
        .qgrant   (qual_grant(grant_in_n, busy_in_n)),
        .ctl_nxt  (req_ctl)
    );

    assign sel_ctl = arb_mode ? host_ctl : req_ctl;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_out_n   <= 1'b1;
            grant_out_n <= 1'b1;
            busy_out_n  <= 1'b1;
            int_own     <= 1'b0;
        end else begin
            req_out_n   <= !sel_ctl.req;
            grant_out_n <= !sel_ctl.grant;
            busy_out_n  <= !sel_ctl.busy;
            int_own     <= sel_ctl.own;
        end
    end

    ebarb_strobe u_strobe (
        .clk         (clk),
        .rst         (rst),
        .own_q       (int_own),
        .int_start   (int_start),
        .int_done    (int_done),
        .ext_tenure  (ext_tenure),
        .ext_busy    (!busy_in_n),
        .ext_start   (!ext_sts_n),
        .ext_burst   (ext_burst),
        .ext_hit_int (ext_hit_int),
        .sts_n       (sts_out_n),
        .bi_n        (bi_out_n)
    );

    // R3: never grant and drive busy at once
    a_r3_no_grant_with_busy: assert property (@(posedge clk) disable iff (rst)
        !(!grant_out_n && !busy_out_n));

    // R4: grant withdrawn after the external master takes busy
    a_r4_grant_drop: assert property (@(posedge clk) disable iff (rst)
        (arb_mode && !grant_out_n && !busy_in_n) |=> grant_out_n);

    // R7: in requester mode busy only follows a qualified grant
    a_r7_busy_after_qgrant: assert property (@(posedge clk) disable iff (rst)
        (!arb_mode && $fell(busy_out_n)) |-> $past(!grant_in_n && busy_in_n));

    // R11: pins unused by the current mode stay negated
    a_r11_mode_pins: assert property (@(posedge clk) disable iff (rst)
        arb_mode ? req_out_n : grant_out_n);

    // R9: start strobe only by the bus owner
    a_r9_sts_owner: assert property (@(posedge clk) disable iff (rst)
        !sts_out_n |-> !busy_out_n);

endmodule

// File: tb/ebarb_top_tb.sv
module ebarb_top_tb;

    logic clk = 1'b0;
    logic rst;
    logic arb_mode, int_req, int_done, int_start, int_own;
    logic req_in_n, req_out_n, grant_in_n, grant_out_n;
    logic busy_in_n, busy_out_n, ext_sts_n, ext_burst, ext_hit_int;
    logic sts_out_n, bi_out_n;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    ebarb_top u_dut (
        .clk(clk), .rst(rst), .arb_mode(arb_mode),
        .int_req(int_req), .int_done(int_done), .int_start(int_start),
        .int_own(int_own),
        .req_in_n(req_in_n), .req_out_n(req_out_n),
        .grant_in_n(grant_in_n), .grant_out_n(grant_out_n),
        .busy_in_n(busy_in_n), .busy_out_n(busy_out_n),
        .ext_sts_n(ext_sts_n), .ext_burst(ext_burst), .ext_hit_int(ext_hit_int),
        .sts_out_n(sts_out_n), .bi_out_n(bi_out_n)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        int_req = 0; int_done = 0; int_start = 0;
        req_in_n = 1; grant_in_n = 1; busy_in_n = 1;
        ext_sts_n = 1; ext_burst = 0; ext_hit_int = 0;
    endtask

    task automatic do_reset(input logic mode);
        arb_mode = mode;
        idle_inputs();
        rst = 1;
        step(); step();
        rst = 0;
    endtask

    task automatic t_reset();
        do_reset(1'b1);
        req_in_n = 0; int_req = 1;
        rst = 1;
        step();
        chk("R1 req_out_n", req_out_n, 1'b1);
        chk("R1 grant_out_n", grant_out_n, 1'b1);
        chk("R1 busy_out_n", busy_out_n, 1'b1);
        chk("R1 sts_out_n", sts_out_n, 1'b1);
        chk("R1 bi_out_n", bi_out_n, 1'b1);
        chk("R1 int_own", int_own, 1'b0);
        rst = 0;
        idle_inputs();
        step();
    endtask

    task automatic t_int_own();
        do_reset(1'b1);
        int_req = 1;
        step();
        chk("R2 busy_out_n on", busy_out_n, 1'b0);
        chk("R2 int_own on", int_own, 1'b1);
        chk("R11 req_out_n arb mode", req_out_n, 1'b1);
        int_start = 1;
        step();
        chk("R9 sts low", sts_out_n, 1'b0);
        int_start = 0;
        step();
        chk("R9 sts one cycle", sts_out_n, 1'b1);
        int_req = 0; int_done = 1;
        step();
        chk("R2 busy_out_n off", busy_out_n, 1'b1);
        chk("R2 int_own off", int_own, 1'b0);
        int_done = 0; int_start = 1;
        step();
        chk("R9 start ignored w/o ownership", sts_out_n, 1'b1);
        int_start = 0;
        step();
    endtask

    task automatic t_ext_grant();
        do_reset(1'b1);
        req_in_n = 0;
        step();
        chk("R3 grant issued", grant_out_n, 1'b0);
        chk("R3 no busy while granted", busy_out_n, 1'b1);
        busy_in_n = 0; ext_sts_n = 0; ext_burst = 1; ext_hit_int = 1;
        step();
        chk("R4 grant withdrawn", grant_out_n, 1'b1);
        chk("R10 bi for internal burst", bi_out_n, 1'b0);
        req_in_n = 1; ext_sts_n = 1;
        step();
        chk("R10 bi held", bi_out_n, 1'b0);
        ext_sts_n = 0; ext_burst = 0;
        step();
        chk("R10 no bi single beat", bi_out_n, 1'b1);
        ext_burst = 1; ext_hit_int = 0;
        step();
        chk("R10 no bi external space", bi_out_n, 1'b1);
        ext_sts_n = 1; ext_burst = 0;
        busy_in_n = 1; req_in_n = 0;
        step();
        chk("R4 gap after tenure", grant_out_n, 1'b1);
        step();
        chk("R4 regrant after gap", grant_out_n, 1'b0);
        req_in_n = 1;
        step();
        chk("R4 grant removed on withdraw", grant_out_n, 1'b1);
    endtask

    task automatic t_both();
        do_reset(1'b1);
        int_req = 1; req_in_n = 0;
        step();
        chk("R5 on-chip first", busy_out_n, 1'b0);
        chk("R5 no grant yet", grant_out_n, 1'b1);
        step();
        int_done = 1;
        step();
        chk("R5 ext granted after done", grant_out_n, 1'b0);
        chk("R5 on-chip released", int_own, 1'b0);
        int_done = 0;
        step();
        chk("R3 busy off while granted", busy_out_n, 1'b1);
        busy_in_n = 0;
        step();
        chk("R5 grant dropped", grant_out_n, 1'b1);
        req_in_n = 1; busy_in_n = 1;
        step();
        step();
        chk("R5 on-chip served again", int_own, 1'b1);
        chk("R5 busy again", busy_out_n, 1'b0);
        int_done = 1; int_req = 0;
        step();
        int_done = 0;
    endtask

    task automatic t_req_mode();
        do_reset(1'b0);
        req_in_n = 0;
        int_req = 1;
        step();
        chk("R6 request out", req_out_n, 1'b0);
        chk("R6 no busy", busy_out_n, 1'b1);
        chk("R11 no grant in requester mode", grant_out_n, 1'b1);
        grant_in_n = 0; busy_in_n = 0;
        step();
        chk("R7 unqualified grant ignored", busy_out_n, 1'b1);
        chk("R7 still requesting", req_out_n, 1'b0);
        busy_in_n = 1;
        step();
        chk("R7 busy on qualified grant", busy_out_n, 1'b0);
        chk("R7 request dropped", req_out_n, 1'b1);
        chk("R7 int_own", int_own, 1'b1);
        grant_in_n = 1; int_start = 1;
        step();
        chk("R9 sts in requester mode", sts_out_n, 1'b0);
        int_start = 0; int_done = 1; int_req = 0;
        step();
        chk("R7 busy released", busy_out_n, 1'b1);
        int_done = 0;
        grant_in_n = 0;
        step();
        int_req = 1;
        step();
        chk("R8 parked: busy at once", busy_out_n, 1'b0);
        chk("R8 parked: no request", req_out_n, 1'b1);
        chk("R11 grant stays high", grant_out_n, 1'b1);
        int_done = 1; int_req = 0;
        step();
        int_done = 0;
        step();
    endtask

    initial begin
        rst = 1;
        arb_mode = 1;
        idle_inputs();
        step();
        t_reset();
        t_int_own();
        t_ext_grant();
        t_both();
        t_req_mode();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule